// File: doc/BRIEF.md
# Lockable Translation Buffer with Victim Pointer

This block is a fully associative address translation buffer of 8 or 32 entries. Each entry pairs a virtual-side word (page tag, page size code, a preserve flag and a valid bit) with a physical-side word (frame address and attribute bits). A combinational lookup port takes a 32-bit device address. It returns a hit flag and the translated physical address. Each entry matches at its own page size: 4 KB, 64 KB, 1 MB or 16 MB.

Software drives the block through a small word-indexed register port. It writes a virtual-side word and a physical-side word into staging registers. A load command then copies them into the entry chosen by a software-visible victim pointer. The same pointer selects which entry the two read-back registers show. A lock register holds the victim pointer and a base index. Entries below the base form a protected region that loads never overwrite.

Two flush commands invalidate entries. The first clears every valid entry whose page covers the staged address. The second clears the whole buffer.

Top module: `tlb_xlat`

## Requirements
- R1: After reset every entry is invalid, the lock register reads 0 and the read-back registers read 0.
- R2: A write to register index 3 (load) copies the staging word at index 1 into the victim entry, with bit 2 (valid) forced to 1, and copies the staging word at index 2 into the same entry. The victim then advances by one and wraps to 0 after entry N-1.
- R3: Bits [1:0] of the virtual-side word select the page size: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB. A lookup hits a valid entry when the address bits above the page size equal the tag bits above the page size. The physical address takes the entry's frame bits above the page size and the lookup address bits below it.
- R4: When several valid entries hit, the lowest-indexed entry supplies the physical address.
- R5: A load while the victim is below the base does not change any entry and does not move the victim.
- R6: A load while the base equals N does not change any entry, and the lock register keeps its value.
- R7: Reading index 6 returns the victim entry's virtual-side word, with bit 2 showing the entry's current valid state. Reading index 7 returns its physical-side word.
- R8: A write to index 4 invalidates every valid entry whose page covers the address held in staging register 1. All other entries keep their state.
- R9: A write to index 5 invalidates every entry and leaves the lock register unchanged.
- R10: The lock register at index 0 holds the victim at bits starting at 4, log2(N) bits wide, and the base at bits starting at 10, log2(N)+1 bits wide. Both fields read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| lk_va_i | input | 32 | Lookup device address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pa_o | output | 32 | Translated physical address, 0 on a miss |

## Verification
Every register write, including the load and flush commands, takes effect at the rising edge where the strobe is sampled. Lookup results and register reads are combinational from state, so their new values are due one edge after the strobe. The bench drives each write on a falling edge and holds it across exactly one rising edge. It then samples reads and lookups on the next falling edge, 1 ns after setting the index or address. Protection and full-region cases are checked by reading the lock register and by lookups and read-backs of the entry that a load could have changed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam logic [2:0] REG_LOCK  = 3'd0;
  localparam logic [2:0] REG_VSTG  = 3'd1;
  localparam logic [2:0] REG_PSTG  = 3'd2;
  localparam logic [2:0] REG_LOAD  = 3'd3;
  localparam logic [2:0] REG_FLONE = 3'd4;
  localparam logic [2:0] REG_FLALL = 3'd5;
  localparam logic [2:0] REG_RDV   = 3'd6;
  localparam logic [2:0] REG_RDP   = 3'd7;

  localparam int BASE_LSB = 10;
  localparam int VICT_LSB = 4;
  localparam int VLD_BIT  = 2;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pgsz_e;

  function automatic logic [31:0] pg_mask(input logic [1:0] sz);
    case (pgsz_e'(sz))
      PG_4K:   pg_mask = 32'hFFFF_F000;
      PG_64K:  pg_mask = 32'hFFFF_0000;
      PG_1M:   pg_mask = 32'hFFF0_0000;
      default: pg_mask = 32'hFF00_0000;
    endcase
  endfunction
endpackage

// File: rtl/tlb_lockctl.sv
module tlb_lockctl #(
  parameter int N  = 32,
  parameter int VW = $clog2(N),
  parameter int BW = VW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [BW-1:0] base_o,
  output logic [VW-1:0] vict_o,
  output logic [31:0]   vstg_o,
  output logic [31:0]   pstg_o,
  output logic          load_o,
  output logic          flone_o,
  output logic          flall_o
);
  import tlb_pkg::*;

  logic [BW-1:0] base_q;
  logic [VW-1:0] vict_q, vict_nxt;
  logic [31:0]   vstg_q, pstg_q;
  logic          load_ok;

  // full region or victim inside protected region blocks the load
  assign load_ok  = (base_q != BW'(N)) && ({1'b0, vict_q} >= base_q);
  assign vict_nxt = (vict_q == VW'(N - 1)) ? '0 : vict_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      vict_q <= '0;
      vstg_q <= '0;
      pstg_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        REG_LOCK: begin
          base_q <= reg_wdata_i[BASE_LSB +: BW];
          vict_q <= reg_wdata_i[VICT_LSB +: VW];
        end
        REG_VSTG: vstg_q <= reg_wdata_i;
        REG_PSTG: pstg_q <= reg_wdata_i;
        REG_LOAD: if (load_ok) vict_q <= vict_nxt;
        default: ;
      endcase
    end
  end

  assign base_o  = base_q;
  assign vict_o  = vict_q;
  assign vstg_o  = vstg_q;
  assign pstg_o  = pstg_q;
  assign load_o  = reg_we_i && (reg_addr_i == REG_LOAD) && load_ok;
  assign flone_o = reg_we_i && (reg_addr_i == REG_FLONE);
  assign flall_o = reg_we_i && (reg_addr_i == REG_FLALL);
endmodule

// File: rtl/tlb_entry.sv
module tlb_entry (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic        inv_i,
  input  logic [31:0] vword_i,
  input  logic [31:0] pword_i,
  input  logic [31:0] lk_va_i,
  input  logic [31:0] fl_va_i,
  output logic [31:0] vword_o,
  output logic [31:0] pword_o,
  output logic        lk_hit_o,
  output logic        fl_hit_o
);
  import tlb_pkg::*;

  logic        valid_q;
  logic [31:0] vword_q, pword_q, mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vword_q <= '0;
      pword_q <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      vword_q <= vword_i | (32'd1 << VLD_BIT);
      pword_q <= pword_i;
    end else if (inv_i) begin
      valid_q <= 1'b0;
    end
  end

  assign mask     = pg_mask(vword_q[1:0]);
  assign lk_hit_o = valid_q && ((lk_va_i & mask) == (vword_q & mask));
  assign fl_hit_o = valid_q && ((fl_va_i & mask) == (vword_q & mask));
  assign vword_o  = {vword_q[31:VLD_BIT+1], vword_q[VLD_BIT] & valid_q, vword_q[VLD_BIT-1:0]};
  assign pword_o  = pword_q;
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        any_o    = 1'b1;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_xlat.sv
module tlb_xlat #(
  parameter int N = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic [31:0] lk_va_i,
  output logic        lk_hit_o,
  output logic [31:0] lk_pa_o
);
  import tlb_pkg::*;

  localparam int VW = $clog2(N);
  localparam int BW = VW + 1;

  logic [BW-1:0] base_w;
  logic [VW-1:0] vict_w, hit_idx;
  logic [31:0]   vstg_w, pstg_w, hit_mask;
  logic          load_w, flone_w, flall_w, hit_any;
  logic [N-1:0]  lk_hit_v, fl_hit_v, gnt_w;
  logic [31:0]   vword_a [N];
  logic [31:0]   pword_a [N];

  tlb_lockctl #(.N(N)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .base_o(base_w), .vict_o(vict_w), .vstg_o(vstg_w), .pstg_o(pstg_w),
    .load_o(load_w), .flone_o(flone_w), .flall_o(flall_w)
  );

  for (genvar i = 0; i < N; i++) begin : g_ent
    tlb_entry u_ent (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .load_i(load_w && (vict_w == VW'(i))),
      .inv_i(flall_w || (flone_w && fl_hit_v[i])),
      .vword_i(vstg_w), .pword_i(pstg_w),
      .lk_va_i(lk_va_i), .fl_va_i(vstg_w),
      .vword_o(vword_a[i]), .pword_o(pword_a[i]),
      .lk_hit_o(lk_hit_v[i]), .fl_hit_o(fl_hit_v[i])
    );
  end

  tlb_first_hit #(.N(N)) u_pick (
    .req_i(lk_hit_v), .gnt_o(gnt_w), .idx_o(hit_idx), .any_o(hit_any)
  );

  assign hit_mask = pg_mask(vword_a[hit_idx][1:0]);
  assign lk_hit_o = hit_any;
  assign lk_pa_o  = hit_any ? ((pword_a[hit_idx] & hit_mask) | (lk_va_i & ~hit_mask)) : '0;

  always_comb begin
    case (reg_addr_i)
      REG_LOCK: reg_rdata_o = (32'(base_w) << BASE_LSB) | (32'(vict_w) << VICT_LSB);
      REG_VSTG: reg_rdata_o = vstg_w;
      REG_PSTG: reg_rdata_o = pstg_w;
      REG_RDV:  reg_rdata_o = vword_a[vict_w];
      REG_RDP:  reg_rdata_o = pword_a[vict_w];
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tlb_xlat_chk.sv
module tlb_xlat_chk #(
  parameter int N  = 32,
  parameter int VW = $clog2(N),
  parameter int BW = VW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [2:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic [BW-1:0] base_i,
  input logic [VW-1:0] vict_i,
  input logic [N-1:0]  gnt_i,
  input logic          hit_i
);
  logic wr_load, wr_lock, wr_flall;
  assign wr_load  = reg_we_i && (reg_addr_i == 3'd3);
  assign wr_lock  = reg_we_i && (reg_addr_i == 3'd0);
  assign wr_flall = reg_we_i && (reg_addr_i == 3'd5);

  // R9
  flush_all_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flall |=> !hit_i);

  // R6
  full_load_holds_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_load && base_i == BW'(N)) |=> ($stable(base_i) && $stable(vict_i)));

  // R5
  protected_load_holds_vict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_load && ({1'b0, vict_i} < base_i)) |=> $stable(vict_i));

  // R2
  victim_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_load && base_i != BW'(N) && ({1'b0, vict_i} >= base_i))
      |=> (vict_i == ((($past(vict_i)) == VW'(N - 1)) ? VW'(0) : $past(vict_i) + VW'(1))));

  // R4
  single_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i) && (hit_i == (gnt_i != '0)));

  // R10
  lock_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lock |=> (base_i == $past(reg_wdata_i[10 +: BW]) && vict_i == $past(reg_wdata_i[4 +: VW])));
endmodule

bind tlb_xlat tlb_xlat_chk #(.N(N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .base_i(base_w), .vict_i(vict_w), .gnt_i(gnt_w), .hit_i(lk_hit_o)
);

// File: tb/tlb_xlat_test.sv
`timescale 1ns/1ps
module tlb_xlat_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] va = '0;
  logic        hit;
  logic [31:0] pa;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tlb_xlat #(.N(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lk_va_i(va),
    .lk_hit_o(hit), .lk_pa_o(pa)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic look(input string req, input logic [31:0] v, input logic h, input logic [31:0] p);
    va = v; #1;
    chk(req, {31'd0, hit}, {31'd0, h});
    if (h) chk(req, pa, p);
  endtask

  task automatic load(input logic [31:0] vw, input logic [31:0] pw);
    wr(3'd1, vw);
    wr(3'd2, pw);
    wr(3'd3, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 lock", d, 32'd0);
    rd(3'd6, d); chk("R1 rdv", d, 32'd0);
    rd(3'd7, d); chk("R1 rdp", d, 32'd0);
    look("R1 miss", 32'h1234_5678, 1'b0, 32'd0);
  endtask

  task automatic t_load_sizes;
    logic [31:0] d;
    load(32'h1234_5000, 32'hABCD_E005);
    rd(3'd0, d); chk("R2 victim step", d, 32'h10);
    look("R3 4k hit", 32'h1234_5678, 1'b1, 32'hABCD_E678);
    look("R3 4k miss", 32'h1234_6000, 1'b0, 32'd0);
    load(32'h2003_0001, 32'h5556_0000);
    look("R3 64k", 32'h2003_ABCD, 1'b1, 32'h5556_ABCD);
    load(32'h3010_0002, 32'h7770_0000);
    look("R3 1m", 32'h301F_FFFC, 1'b1, 32'h777F_FFFC);
    load(32'h4400_0003, 32'h0900_0000);
    look("R3 16m", 32'h44AB_CDEF, 1'b1, 32'h09AB_CDEF);
  endtask

  task automatic t_priority;
    load(32'h1234_5000, 32'h1111_1000);
    look("R4 lowest wins", 32'h1234_5678, 1'b1, 32'hABCD_E678);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(3'd0, 32'h10);
    rd(3'd0, d); chk("R10 lock fields", d, 32'h10);
    rd(3'd6, d); chk("R7 rdv", d, 32'h2003_0005);
    rd(3'd7, d); chk("R7 rdp", d, 32'h5556_0000);
    wr(3'd0, 32'h40);
    rd(3'd6, d); chk("R7 rdv e4", d, 32'h1234_5004);
  endtask

  task automatic t_protect;
    logic [31:0] d;
    wr(3'd0, 32'h1420);
    load(32'h5000_0000, 32'h6000_0000);
    rd(3'd0, d); chk("R5 lock held", d, 32'h1420);
    look("R5 no entry", 32'h5000_0000, 1'b0, 32'd0);
    rd(3'd6, d); chk("R5 entry2 kept", d, 32'h3010_0006);
  endtask

  task automatic t_full;
    logic [31:0] d;
    wr(3'd0, 32'h8050);
    load(32'h7000_0000, 32'h7100_0000);
    rd(3'd0, d); chk("R6 lock held", d, 32'h8050);
    look("R6 no entry", 32'h7000_0000, 1'b0, 32'd0);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(3'd0, 32'h1F0);
    load(32'h8000_0000, 32'h9000_0000);
    rd(3'd0, d); chk("R2 wrap", d, 32'h0);
    look("R2 loaded e31", 32'h8000_0ABC, 1'b1, 32'h9000_0ABC);
  endtask

  task automatic t_flush_one;
    wr(3'd1, 32'h2003_8000);
    wr(3'd4, 32'd0);
    look("R8 covered gone", 32'h2003_ABCD, 1'b0, 32'd0);
    look("R8 other kept", 32'h301F_FFFC, 1'b1, 32'h777F_FFFC);
    wr(3'd1, 32'h3020_0000);
    wr(3'd4, 32'd0);
    look("R8 outside kept", 32'h3010_0000, 1'b1, 32'h7770_0000);
    wr(3'd1, 32'h1234_5000);
    wr(3'd4, 32'd0);
    look("R8 both dups gone", 32'h1234_5678, 1'b0, 32'd0);
  endtask

  task automatic t_flush_all;
    logic [31:0] d;
    wr(3'd0, 32'h0C30);
    wr(3'd5, 32'd0);
    look("R9 1m gone", 32'h301F_FFFC, 1'b0, 32'd0);
    look("R9 16m gone", 32'h44AB_CDEF, 1'b0, 32'd0);
    look("R9 e31 gone", 32'h8000_0000, 1'b0, 32'd0);
    rd(3'd0, d); chk("R9 lock kept", d, 32'h0C30);
  endtask

  initial begin
    #5000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #15 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_sizes();
    t_priority();
    t_readback();
    t_protect();
    t_full();
    t_wrap();
    t_flush_one();
    t_flush_all();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule